// File: doc/BRIEF.md
# Thread Fetch Remerge Controller

This block steers instruction fetch for two hardware threads that run the same program. While both threads sit on the same path they share a single fetch, and each fetched instruction carries an ownership mask marking both threads. When a branch resolves differently for the two threads, fetch becomes independent. From then on every taken-branch target of each thread is written into that thread's own small associative history. In the same cycle the target is looked up in the other thread's history.

A lookup hit means the thread that produced the target is trailing along a path the other thread already took. The block then favours that lagging thread for fetch until the two paths realign. If the lagging thread takes a branch that the leading thread never took, the match was false, and fetch returns to equal priority. As soon as both threads present the same fetch PC, shared fetch resumes and both histories are emptied.

Top module: `fetch_remerge_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is in the merged mode. In this state mode_o is 0, prio_o is 2'b00, shared_fetch_o is 1 and own_mask_o is 4'b0011.
- R2: In the merged mode, shared_fetch_o is 1 and own_mask_o is 4'b0011 (bit 0 is thread 0, bit 1 is thread 1, bits 3:2 are zero). The mode stays merged until diverge_i is seen, and taken branches in this mode have no effect on the mode.
- R3: diverge_i sampled high in the merged mode moves the block to the detect mode (mode_o = 1) on the next cycle.
- R4: In the detect mode, a taken-branch target of a thread is written into its own history and searched in the other thread's history as it stood before that cycle. A hit moves the block to the catch-up mode (mode_o = 2) on the next cycle. Bit t of prio_o is then 1 for lagging thread t, and the other bit is 0.
- R5: If both threads hit in the same detect cycle, thread 0 is the lagging thread (prio_o = 2'b01).
- R6: In the catch-up mode, a lagging-thread target that misses in the leading thread's history returns the block to the detect mode with prio_o = 2'b00. A lagging-thread hit, or any branch of the leading thread, keeps the catch-up mode and its priority.
- R7: In the detect or catch-up mode, equal fetch PCs on both threads move the block to the merged mode on the next cycle. Both histories are emptied, so a target recorded before the merge is not found after the next divergence.
- R8: Each history holds HIST_DEPTH (default 32) entries as a circular buffer. After HIST_DEPTH+1 writes, the first target is no longer found and the second still is.
- R9: Outside the merged mode, shared_fetch_o is 0 and own_mask_o is 0. In the detect mode, prio_o is 2'b00.
- R10: diverge_i has no effect in the detect and catch-up modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc0_i | input | PC_W | Thread 0 fetch PC |
| pc1_i | input | PC_W | Thread 1 fetch PC |
| br0_vld_i | input | 1 | Thread 0 taken branch this cycle |
| br0_tgt_i | input | PC_W | Thread 0 taken-branch target |
| br1_vld_i | input | 1 | Thread 1 taken branch this cycle |
| br1_tgt_i | input | PC_W | Thread 1 taken-branch target |
| diverge_i | input | 1 | Branch outcome differs between threads |
| mode_o | output | 2 | 0 merged, 1 detect, 2 catch-up |
| prio_o | output | 2 | Per-thread raised fetch priority (equal bits: round robin) |
| shared_fetch_o | output | 1 | One fetch serves both threads |
| own_mask_o | output | MASK_W | Thread-ownership mask of the fetched instruction |

## Verification
Each mode change, and the priority, sharing and mask outputs that follow from the mode, appear one clock edge after the input that causes them. A history write becomes visible to lookups after that same edge. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and compares all outputs at the next falling edge. Every expected value is therefore the state that edge produced.

// File: rtl/remerge_pkg.sv
package remerge_pkg;

    typedef enum logic [1:0] {
        MODE_MERGED  = 2'd0,
        MODE_DETECT  = 2'd1,
        MODE_CATCHUP = 2'd2
    } fetch_mode_e;

    typedef struct packed {
        fetch_mode_e mode;
        logic        lag;   // index of the lagging thread in catch-up
    } fsm_state_t;

endpackage

// File: rtl/hist_cam.sv
module hist_cam #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            wr_i,
    input  logic [PC_W-1:0] wr_pc_i,
    input  logic [PC_W-1:0] srch_pc_i,
    output logic            hit_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] ent;
        logic [DEPTH-1:0]           vld;
        logic [IDX_W-1:0]           ptr;
    } cam_t;

    cam_t st_d, st_q;
    logic [DEPTH-1:0] match_w;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
            assign match_w[i] = st_q.vld[i] && (st_q.ent[i] == srch_pc_i);
        end
    endgenerate

    assign hit_o = |match_w;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.vld = '0;
            st_d.ptr = '0;
        end else if (wr_i) begin
            st_d.ent[st_q.ptr] = wr_pc_i;
            st_d.vld[st_q.ptr] = 1'b1;
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld <= '0;
            st_q.ptr <= '0;
            st_q.ent <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/remerge_fsm.sv
module remerge_fsm
    import remerge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pc_eq_i,
    input  logic        diverge_i,
    input  logic [1:0]  br_vld_i,
    input  logic [1:0]  hit_i,     // hit_i[t]: thread t target found in the other history
    output fetch_mode_e mode_o,
    output logic        lag_o
);
    fsm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MODE_MERGED: begin
                if (diverge_i) st_d.mode = MODE_DETECT;
            end
            MODE_DETECT: begin
                if (pc_eq_i) begin
                    st_d.mode = MODE_MERGED;
                end else if (hit_i[0]) begin
                    st_d.mode = MODE_CATCHUP;
                    st_d.lag  = 1'b0;
                end else if (hit_i[1]) begin
                    st_d.mode = MODE_CATCHUP;
                    st_d.lag  = 1'b1;
                end
            end
            MODE_CATCHUP: begin
                if (pc_eq_i) begin
                    st_d.mode = MODE_MERGED;
                end else if (br_vld_i[st_q.lag] && !hit_i[st_q.lag]) begin
                    st_d.mode = MODE_DETECT;
                end
            end
            default: st_d.mode = MODE_MERGED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_MERGED;
            st_q.lag  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign lag_o  = st_q.lag;
endmodule

// File: rtl/fetch_grant.sv
module fetch_grant
    import remerge_pkg::*;
#(
    parameter int MASK_W = 4
) (
    input  fetch_mode_e       mode_i,
    input  logic              lag_i,
    output logic [1:0]        prio_o,
    output logic              shared_o,
    output logic [MASK_W-1:0] mask_o
);
    localparam logic [MASK_W-1:0] BOTH = MASK_W'(2'b11);

    always_comb begin
        prio_o   = 2'b00;
        shared_o = 1'b0;
        mask_o   = '0;
        if (mode_i == MODE_MERGED) begin
            shared_o = 1'b1;
            mask_o   = BOTH;
        end else if (mode_i == MODE_CATCHUP) begin
            prio_o = lag_i ? 2'b10 : 2'b01;
        end
    end
endmodule

// File: rtl/fetch_remerge_ctrl.sv
module fetch_remerge_ctrl
    import remerge_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int HIST_DEPTH = 32,
    parameter int MASK_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pc0_i,
    input  logic [PC_W-1:0]   pc1_i,
    input  logic              br0_vld_i,
    input  logic [PC_W-1:0]   br0_tgt_i,
    input  logic              br1_vld_i,
    input  logic [PC_W-1:0]   br1_tgt_i,
    input  logic              diverge_i,
    output logic [1:0]        mode_o,
    output logic [1:0]        prio_o,
    output logic              shared_fetch_o,
    output logic [MASK_W-1:0] own_mask_o
);
    localparam int NTHR = 2;

    fetch_mode_e           mode_w;
    logic                  lag_w;
    logic [NTHR-1:0]       vld_w;
    logic [PC_W-1:0]       tgt_w [NTHR];
    logic [NTHR-1:0]       cam_hit_w;
    logic [NTHR-1:0]       thr_hit_w;
    logic                  rec_en_w;
    logic                  clr_w;

    assign vld_w    = {br1_vld_i, br0_vld_i};
    assign tgt_w[0] = br0_tgt_i;
    assign tgt_w[1] = br1_tgt_i;
    assign rec_en_w = (mode_w != MODE_MERGED);
    assign clr_w    = (mode_w == MODE_MERGED);

    generate
        for (genvar t = 0; t < NTHR; t++) begin : g_thr
            // history t holds thread t targets, searched by the other thread
            hist_cam #(.PC_W(PC_W), .DEPTH(HIST_DEPTH)) u_hist (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr_i     (clr_w),
                .wr_i      (rec_en_w && vld_w[t]),
                .wr_pc_i   (tgt_w[t]),
                .srch_pc_i (tgt_w[NTHR-1-t]),
                .hit_o     (cam_hit_w[t])
            );
            assign thr_hit_w[t] = vld_w[t] && cam_hit_w[NTHR-1-t];
        end
    endgenerate

    remerge_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_eq_i   (pc0_i == pc1_i),
        .diverge_i (diverge_i),
        .br_vld_i  (vld_w),
        .hit_i     (thr_hit_w),
        .mode_o    (mode_w),
        .lag_o     (lag_w)
    );

    fetch_grant #(.MASK_W(MASK_W)) u_grant (
        .mode_i   (mode_w),
        .lag_i    (lag_w),
        .prio_o   (prio_o),
        .shared_o (shared_fetch_o),
        .mask_o   (own_mask_o)
    );

    assign mode_o = mode_w;
endmodule

// File: rtl/fetch_remerge_checker.sv
module fetch_remerge_checker #(
    parameter int PC_W   = 32,
    parameter int MASK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   pc0_i,
    input logic [PC_W-1:0]   pc1_i,
    input logic              diverge_i,
    input logic [1:0]        mode_o,
    input logic [1:0]        prio_o,
    input logic              shared_fetch_o,
    input logic [MASK_W-1:0] own_mask_o
);
    p_stay_merged_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && !diverge_i) |=> (mode_o == 2'd0));

    p_split_on_diverge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && diverge_i) |=> (mode_o == 2'd1));

    p_no_skip_to_catchup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |=> (mode_o != 2'd2));

    p_single_lagger_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> ($countones(prio_o) == 1));

    p_remerge_on_equal_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd0 && pc0_i == pc1_i) |=> (mode_o == 2'd0));

    p_detect_equal_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |-> (prio_o == 2'b00 && !shared_fetch_o && own_mask_o == '0));

    p_legal_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd3));
endmodule

bind fetch_remerge_ctrl fetch_remerge_checker #(.PC_W(PC_W), .MASK_W(MASK_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pc0_i          (pc0_i),
    .pc1_i          (pc1_i),
    .diverge_i      (diverge_i),
    .mode_o         (mode_o),
    .prio_o         (prio_o),
    .shared_fetch_o (shared_fetch_o),
    .own_mask_o     (own_mask_o)
);

// File: tb/tb_fetch_remerge_ctrl.sv
module tb_fetch_remerge_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pc0, pc1, b0t, b1t;
    logic        b0v, b1v, div;
    logic [1:0]  mode, prio;
    logic        shared;
    logic [3:0]  mask;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fetch_remerge_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pc0_i(pc0), .pc1_i(pc1),
        .br0_vld_i(b0v), .br0_tgt_i(b0t), .br1_vld_i(b1v), .br1_tgt_i(b1t),
        .diverge_i(div), .mode_o(mode), .prio_o(prio),
        .shared_fetch_o(shared), .own_mask_o(mask)
    );

    typedef struct packed {
        logic [31:0] pc0;
        logic [31:0] pc1;
        logic        b0v;
        logic [31:0] b0t;
        logic        b1v;
        logic [31:0] b1t;
        logic        div;
        logic [1:0]  emode;
        logic [1:0]  eprio;
        logic        eshared;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{32'h100, 32'h100, 1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 2'd0, 2'b00, 1'b1}, // R2 idle merged
        '{32'h100, 32'h200, 1'b1, 32'hA0,   1'b1, 32'hA0,   1'b0, 2'd0, 2'b00, 1'b1}, // R2 branches ignored
        '{32'h100, 32'h200, 1'b0, 32'h0,    1'b0, 32'h0,    1'b1, 2'd1, 2'b00, 1'b0}, // R3 diverge
        '{32'h100, 32'h200, 1'b0, 32'h0,    1'b0, 32'h0,    1'b1, 2'd1, 2'b00, 1'b0}, // R10 in detect
        '{32'h100, 32'h200, 1'b1, 32'h1000, 1'b0, 32'h0,    1'b0, 2'd1, 2'b00, 1'b0}, // R4 miss
        '{32'h100, 32'h200, 1'b0, 32'h0,    1'b1, 32'h2000, 1'b0, 2'd1, 2'b00, 1'b0}, // R4 miss
        '{32'h100, 32'h200, 1'b0, 32'h0,    1'b1, 32'h3000, 1'b0, 2'd1, 2'b00, 1'b0}, // R4 miss
        '{32'h100, 32'h200, 1'b1, 32'h3000, 1'b0, 32'h0,    1'b0, 2'd2, 2'b01, 1'b0}, // R4 hit, t0 lags
        '{32'h100, 32'h200, 1'b0, 32'h0,    1'b1, 32'h5000, 1'b0, 2'd2, 2'b01, 1'b0}, // R6 leader branch
        '{32'h100, 32'h200, 1'b1, 32'h5000, 1'b0, 32'h0,    1'b0, 2'd2, 2'b01, 1'b0}, // R6 lagger hit
        '{32'h100, 32'h200, 1'b0, 32'h0,    1'b0, 32'h0,    1'b1, 2'd2, 2'b01, 1'b0}, // R10 in catch-up
        '{32'h100, 32'h200, 1'b1, 32'h7777, 1'b0, 32'h0,    1'b0, 2'd1, 2'b00, 1'b0}, // R6 lagger miss
        '{32'h100, 32'h200, 1'b1, 32'h2000, 1'b1, 32'h1000, 1'b0, 2'd2, 2'b01, 1'b0}, // R5 both hit
        '{32'h400, 32'h400, 1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 2'd0, 2'b00, 1'b1}, // R7 remerge from catch-up
        '{32'h100, 32'h200, 1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 2'd0, 2'b00, 1'b1}, // R2 stays merged
        '{32'h100, 32'h200, 1'b0, 32'h0,    1'b0, 32'h0,    1'b1, 2'd1, 2'b00, 1'b0}, // R3 diverge again
        '{32'h100, 32'h200, 1'b1, 32'h2000, 1'b0, 32'h0,    1'b0, 2'd1, 2'b00, 1'b0}, // R7 history cleared
        '{32'h100, 32'h200, 1'b0, 32'h0,    1'b1, 32'h2000, 1'b0, 2'd2, 2'b10, 1'b0}, // R4 t1 lags
        '{32'h100, 32'h200, 1'b0, 32'h0,    1'b1, 32'h9999, 1'b0, 2'd1, 2'b00, 1'b0}, // R6 lagger miss
        '{32'h300, 32'h300, 1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 2'd0, 2'b00, 1'b1}  // R7 remerge from detect
    };

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic check(string req, logic [1:0] em, logic [1:0] ep, logic es);
        logic [3:0] emask;
        emask = es ? 4'b0011 : 4'b0000;
        checks++;
        if (mode !== em || prio !== ep || shared !== es || mask !== emask) begin
            errors++;
            $display("FAIL %s: mode/prio/shared/mask got %0d/%b/%b/%b expected %0d/%b/%b/%b",
                     req, mode, prio, shared, mask, em, ep, es, emask);
        end
    endtask

    task automatic idle_inputs();
        b0v = 0; b1v = 0; b0t = '0; b1t = '0; div = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle_inputs();
        pc0 = 32'h100; pc1 = 32'h100;
        step();
        step();
        check("R1 in reset", 2'd0, 2'b00, 1'b1);
        rst_n = 1;
        step();
        check("R1 after reset", 2'd0, 2'b00, 1'b1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not end, got hang expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            pc0 = VECS[i].pc0; pc1 = VECS[i].pc1;
            b0v = VECS[i].b0v; b0t = VECS[i].b0t;
            b1v = VECS[i].b1v; b1t = VECS[i].b1t;
            div = VECS[i].div;
            step();
            check($sformatf("table row %0d", i), VECS[i].emode, VECS[i].eprio, VECS[i].eshared);
        end

        // R1: reset from catch-up returns to merged
        idle_inputs();
        pc0 = 32'h100; pc1 = 32'h200; div = 1; step(); idle_inputs();
        b1v = 1; b1t = 32'h44; step(); idle_inputs();
        b0v = 1; b0t = 32'h44; step(); idle_inputs();
        check("R4 setup before reset", 2'd2, 2'b01, 1'b0);
        do_reset();

        // R8: wrap-around of the circular history
        pc0 = 32'h100; pc1 = 32'h200; div = 1; step(); idle_inputs();
        check("R3 before wrap test", 2'd1, 2'b00, 1'b0);
        for (int k = 0; k <= 32; k++) begin
            b0v = 1; b0t = 32'h8000 + 32'(k * 4);
            step();
        end
        idle_inputs();
        check("R8 fill stays detect", 2'd1, 2'b00, 1'b0);
        b1v = 1; b1t = 32'h8000; step(); idle_inputs();
        check("R8 oldest overwritten", 2'd1, 2'b00, 1'b0);
        b1v = 1; b1t = 32'h8004; step(); idle_inputs();
        check("R8 second entry kept", 2'd2, 2'b10, 1'b0);

        finish_run();
    end
endmodule